// File: doc/BRIEF.md
# Dual-Processor Mailbox Port

This block lets two processors exchange bytes through one shared port. The master side uses a plain register interface: a one-cycle write pulse loads the outbound byte, and a one-cycle read pulse acknowledges the inbound byte, which is always visible on a read-data output. The slave side has asynchronous, active-low chip-select, read and write pins. These pins are synchronized to the system clock and then decoded into a slave-read term and a slave-write term.

While the slave-read term is active, the outbound byte is driven toward the slave. At all other times the slave data path is released: the enable output is low and the data output is zero. When the slave-write term ends, the byte on the slave data input is captured into input capture cells, which the master reads directly. Two flags tell each side when unread data is waiting. One flag means the master has written and the slave has not yet read. The other means the slave has written and the master has not yet read.

Top module: `mbx_port`

## Requirements
- R1: After reset, the outbound register, the capture cells, both flags and the slave output enable are all zero.
- R2: A master write pulse (`m_wr_en`=1 at a clock edge) loads `m_wdata` into the outbound register and sets `m2s_full` from the next cycle on.
- R3: The slave-read term is active when, after synchronization, `s_cs_n`=0, `s_rd_n`=0 and `s_wr_n`=1. While it is active, `s_data_oe`=1 and `s_data_out` carries the outbound register.
- R4: When the slave-read term ends, `m2s_full` is cleared. A master write in the same cycle wins and leaves the flag set with the new byte.
- R5: The slave-write term is active when, after synchronization, `s_cs_n`=0, `s_wr_n`=0 and `s_rd_n`=1. When it ends, `s_data_in` is captured, `m_rdata` shows the captured byte, and `s2m_full` is set.
- R6: A master read pulse (`m_rd_en`=1) clears `s2m_full`. A slave-write completion in the same cycle wins and leaves the flag set.
- R7: With `s_cs_n`=1, or with both `s_rd_n` and `s_wr_n` low, neither term is active: nothing is captured, no flag changes and `s_data_oe` stays 0.
- R8: Whenever `s_data_oe`=0, `s_data_out` is zero.
- R9: The two directions are independent. A slave write never alters the outbound register, and a master write never alters the capture cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_wr_en | input | 1 | Master write pulse for the outbound register |
| m_wdata | input | DATA_W | Master write data |
| m_rd_en | input | 1 | Master read acknowledge; clears the inbound flag |
| m_rdata | output | DATA_W | Contents of the capture cells |
| m2s_full | output | 1 | Outbound byte is waiting for the slave |
| s2m_full | output | 1 | Inbound byte is waiting for the master |
| s_cs_n | input | 1 | Slave chip select, active low, asynchronous |
| s_rd_n | input | 1 | Slave read strobe, active low, asynchronous |
| s_wr_n | input | 1 | Slave write strobe, active low, asynchronous |
| s_data_in | input | DATA_W | Byte written by the slave |
| s_data_out | output | DATA_W | Byte driven to the slave during a read, otherwise zero |
| s_data_oe | output | 1 | Drive enable toward the slave bus |

## Verification
Random sequences mix master writes, master reads, slave reads and slave writes with random bytes. These separate correct handshaking from flags that stick or clear at the wrong event. Illegal strobe patterns, such as both strobes low or strobes with chip select high, are interleaved with the legal ones, so a decoder that ignores one of the three pins shows up as a spurious capture or a spurious drive. Directed cases place a master write on the exact cycle a slave read ends, and a master read on the exact cycle a slave write ends. These cases expose a reversed set-over-clear priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef struct packed {
        logic rd_on;
        logic wr_on;
        logic rd_done;
        logic wr_done;
    } mbx_term_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], pin_i[b]};
        end
        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cs_n,
    input  logic      rd_n,
    input  logic      wr_n,
    output mbx_term_t term_o
);
    typedef struct packed {
        logic rd_prev;
        logic wr_prev;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic rd_on, wr_on;

    always_comb begin
        rd_on = !cs_n && !rd_n && wr_n;
        wr_on = !cs_n && !wr_n && rd_n;
        st_d.rd_prev = rd_on;
        st_d.wr_prev = wr_on;
        term_o.rd_on   = rd_on;
        term_o.wr_on   = wr_on;
        term_o.rd_done = st_q.rd_prev && !rd_on;
        term_o.wr_done = st_q.wr_prev && !wr_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: the two terms are never active at once
    a_r7_terms_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_on && wr_on));
endmodule

// File: rtl/mbx_port.sv
module mbx_port
    import mbx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_wr_en,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic              m_rd_en,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m2s_full,
    output logic              s2m_full,
    input  logic              s_cs_n,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic [DATA_W-1:0] s_data_in,
    output logic [DATA_W-1:0] s_data_out,
    output logic              s_data_oe
);
    localparam int PIN_N = 3;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] cap;
        logic              m2s;
        logic              s2m;
    } port_state_t;

    port_state_t st_d, st_q;
    logic [PIN_N-1:0] pins_sync;
    mbx_term_t        term;

    mbx_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({s_cs_n, s_rd_n, s_wr_n}),
        .sync_o (pins_sync)
    );

    mbx_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (pins_sync[2]),
        .rd_n   (pins_sync[1]),
        .wr_n   (pins_sync[0]),
        .term_o (term)
    );

    always_comb begin
        st_d = st_q;
        if (m_wr_en) st_d.dout = m_wdata;
        if (term.wr_done) st_d.cap = s_data_in;
        if (m_wr_en)           st_d.m2s = 1'b1;
        else if (term.rd_done) st_d.m2s = 1'b0;
        if (term.wr_done)      st_d.s2m = 1'b1;
        else if (m_rd_en)      st_d.s2m = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_rdata    = st_q.cap;
    assign m2s_full   = st_q.m2s;
    assign s2m_full   = st_q.s2m;
    assign s_data_oe  = term.rd_on;
    assign s_data_out = term.rd_on ? st_q.dout : '0;

    a_r2_master_load: assert property (@(posedge clk) disable iff (!rst_n)
        m_wr_en |=> (m2s_full && s_data_out == (s_data_oe ? $past(m_wdata) : '0)));
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (term.rd_done && !m_wr_en) |=> !m2s_full);
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        term.wr_done |=> (s2m_full && m_rdata == $past(s_data_in)));
    a_r6_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (m_rd_en && !term.wr_done) |=> !s2m_full);
    a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
        !s_data_oe |-> s_data_out == '0);
    a_r9_cap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !term.wr_done |=> $stable(m_rdata));
endmodule

// File: tb/mbx_port_bench.sv
module mbx_port_bench;
    localparam int W = 8;
    logic clk = 0, rst_n = 0;
    logic m_wr_en = 0, m_rd_en = 0;
    logic [W-1:0] m_wdata = '0, s_data_in = '0;
    logic s_cs_n = 1, s_rd_n = 1, s_wr_n = 1;
    logic [W-1:0] m_rdata, s_data_out;
    logic m2s_full, s2m_full, s_data_oe;
    int checks = 0, errors = 0;
    logic [W-1:0] e_dout = '0, e_cap = '0;
    logic e_m2s = 0, e_s2m = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbx_port u_mbx_port (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_flags();
        return {30'd0, e_m2s, e_s2m};
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_state(input string req);
        chk(req, exp_flags(), {30'd0, m2s_full, s2m_full});
        chk(req, m_rdata, e_cap);
        chk({req, "_oe"}, s_data_oe, 0);
        chk({req, "_out"}, s_data_out, 0);
    endtask

    task automatic master_write(input logic [W-1:0] d);
        m_wr_en = 1; m_wdata = d; @(negedge clk); m_wr_en = 0;
        e_dout = d; e_m2s = 1;
        check_state("R2");
    endtask

    task automatic master_read();
        m_rd_en = 1; @(negedge clk); m_rd_en = 0;
        e_s2m = 0;
        check_state("R6");
    endtask

    task automatic slave_read();
        s_cs_n = 0; s_rd_n = 0; idle(5);
        chk("R3_oe", s_data_oe, 1);
        chk("R3_data", s_data_out, e_dout);
        s_cs_n = 1; s_rd_n = 1; idle(5);
        e_m2s = 0;
        check_state("R4");
    endtask

    task automatic slave_write(input logic [W-1:0] d);
        s_data_in = d; s_cs_n = 0; s_wr_n = 0; idle(5);
        chk("R8_during_write", s_data_out, 0);
        s_cs_n = 1; s_wr_n = 1; idle(5);
        e_cap = d; e_s2m = 1;
        s_data_in = ~d;
        check_state("R5");
    endtask

    // R7: illegal strobe patterns must do nothing
    task automatic slave_bogus(input int kind, input logic [W-1:0] d);
        s_data_in = d;
        case (kind)
            0: begin s_cs_n = 0; s_rd_n = 0; s_wr_n = 0; end
            1: begin s_cs_n = 1; s_rd_n = 0; end
            default: begin s_cs_n = 1; s_wr_n = 0; end
        endcase
        idle(5);
        chk("R7_oe", s_data_oe, 0);
        s_cs_n = 1; s_rd_n = 1; s_wr_n = 1; idle(5);
        check_state("R7");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        check_state("R1");

        // directed: master write on the exact cycle the slave read ends (R4 priority)
        master_write(8'hA5);
        s_cs_n = 0; s_rd_n = 0; idle(5);
        s_cs_n = 1; s_rd_n = 1;
        idle(2);
        m_wr_en = 1; m_wdata = 8'h3C; @(negedge clk); m_wr_en = 0;
        e_dout = 8'h3C; e_m2s = 1;
        idle(3);
        check_state("R4_priority");
        slave_read();

        // directed: master read on the exact cycle the slave write ends (R6 priority)
        s_data_in = 8'h77; s_cs_n = 0; s_wr_n = 0; idle(5);
        s_cs_n = 1; s_wr_n = 1;
        idle(2);
        m_rd_en = 1; @(negedge clk); m_rd_en = 0;
        e_cap = 8'h77; e_s2m = 1;
        idle(3);
        check_state("R6_priority");
        master_read();

        // R9: independent directions
        master_write(8'h11);
        slave_write(8'h22);
        slave_read();
        chk("R9_cap", m_rdata, 8'h22);
        master_write(8'h33);
        chk("R9_cap_after_mwrite", m_rdata, 8'h22);

        for (int i = 0; i < 300; i++) begin
            case ($urandom % 5)
                0: master_write(W'($urandom));
                1: master_read();
                2: slave_read();
                3: slave_write(W'($urandom));
                default: slave_bogus(int'($urandom % 3), W'($urandom));
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule